// File: doc/BRIEF.md
# Pipelined DRAM Bus Controller

This block links a processor's internal memory request port directly to an external DRAM array, with no external SRAM cache between them. It takes read and write requests, each with an address, byte enables and write data. It starts the address cycle for a new request before the data of earlier requests has come back, so that a slow DRAM array does not hold up the requester. Up to three bus cycles can be outstanding at once. Their data phases are served and acknowledged strictly in the order the requests were issued.

On every address cycle the controller compares the DRAM page of the new access with the page of the access before it. It raises a separate same-page flag when the two match, so that the memory can use a static column access and skip a new row cycle. A mode input narrows the data bus to 8 bits, which lets the processor boot from a byte-wide ROM. In that mode each 64-bit transfer runs as eight byte beats, and only one transfer is in flight at a time.

Top module: `dram_pipe_ctrl`

## Requirements
- R1: A request is accepted in any cycle in which `req_valid` and `req_ready` are both high. The address cycle is issued in that same cycle: `bus_adr_valid` is high, `bus_addr` carries the request address and `bus_adr_wr` carries its direction (1 = write).
- R2: In 64-bit mode `req_ready` is high exactly when fewer than three accepted transfers are still waiting to be retired. The number outstanding never exceeds three.
- R3: `req_ready` depends only on registered state. When three transfers are outstanding, a retirement in a cycle does not admit a request in that same cycle. The request is admitted in the following cycle.
- R4: Transfers retire in issue order. A transfer retires on a cycle in which `dat_ready` is high while its final data beat is on the bus. Exactly one cycle later `rsp_valid` pulses for one cycle. With it, `rsp_write` gives the direction and `rsp_rdata` gives the read word, or zero for a write.
- R5: `dat_active` is high exactly while at least one transfer is outstanding. During that time `dat_wr`, `dat_be` and `dat_wdata` present the oldest transfer, and they hold steady until `dat_ready` advances it.
- R6: The page of an address is its bits from `ADDR_W-1` down to `COL_W` (default 31..11). When an accepted address has the same page as the previously accepted one, `bus_near` is high during its address cycle.
- R7: The remembered page is cleared at reset and in any cycle that ends with nothing outstanding and nothing accepted. The first access after reset or after idle therefore has `bus_near` low. `bus_near` is never high without `bus_adr_valid`.
- R8: With `byte_mode` high, `req_ready` is high only when nothing is outstanding. Each transfer takes eight beats, numbered 0 to 7 on `dat_beat`, and `dat_ready` advances one beat. On beat k, `dat_be` is `{7'b0, be[k]}` and `dat_wdata` is `{56'b0, wdata[8k+7:8k]}`. In 64-bit mode `dat_beat` stays at 0 and a single `dat_ready` retires the transfer. `byte_mode` may change only while the controller is idle.
- R9: In byte mode, read beat k places `dat_rdata[7:0]` into bits 8k+7..8k of `rsp_rdata`, so byte 0 is the least significant byte.
- R10: After reset, `req_ready` is high and `bus_adr_valid`, `bus_near`, `dat_active` and `rsp_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | Selects the 8-bit boot bus |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | Request direction, 1 = write |
| req_addr | input | ADDR_W | Request byte address |
| req_be | input | 8 | Request byte enables |
| req_wdata | input | 64 | Request write data |
| rsp_valid | output | 1 | Completion pulse |
| rsp_write | output | 1 | Direction of the completed transfer |
| rsp_rdata | output | 64 | Read word, or zero for a write |
| bus_adr_valid | output | 1 | Address cycle strobe |
| bus_addr | output | ADDR_W | Address cycle address |
| bus_adr_wr | output | 1 | Address cycle direction |
| bus_near | output | 1 | Same-page flag for static column access |
| dat_active | output | 1 | Data phase for the oldest transfer is open |
| dat_wr | output | 1 | Direction of the data phase |
| dat_be | output | 8 | Byte enables of the current beat |
| dat_beat | output | 3 | Beat index in byte mode |
| dat_wdata | output | 64 | Write data of the current beat |
| dat_rdata | input | 64 | Read data from memory |
| dat_ready | input | 1 | Memory completes the current beat |

## Verification
Two things can happen in the same cycle: a new address cycle can be issued while the oldest data phase retires, and a same-page decision can be made while the page memory is about to be cleared for idle. The bench provokes the first by holding `dat_ready` low until three transfers are queued, and by running a slow ready pattern behind streams of requests sent back to back. It provokes the second by draining the bus and then revisiting the last page. A scoreboard predicts, cycle by cycle, the readiness, the same-page flag, the data-phase contents and the completion words, and it judges each of them independently of the design.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
   localparam int DPC_DATA_W = 64;
   localparam int DPC_LANES  = DPC_DATA_W / 8;
   localparam int DPC_BEAT_W = $clog2(DPC_LANES);
   typedef logic [DPC_DATA_W-1:0] dpc_word_t;
   typedef logic [DPC_LANES-1:0]  dpc_be_t;
endpackage

// File: rtl/dpc_queue.sv
module dpc_queue #(
   parameter int DEPTH = 3,
   parameter int W     = 8,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     dout,
   output logic [CNT_W-1:0] count
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]     slot [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) slot[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= nxt(wr_ptr);
         if (pop)  rd_ptr <= nxt(rd_ptr);
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign dout = slot[rd_ptr];
endmodule

// File: rtl/dpc_page_track.sv
module dpc_page_track #(
   parameter int ADDR_W = 32,
   parameter int COL_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              idle_next,
   input  logic [ADDR_W-1:0] addr,
   output logic              near
);
   localparam int PG_W = ADDR_W - COL_W;

   logic [PG_W-1:0] last_page;
   logic            page_known;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_known <= 1'b0;
         last_page  <= '0;
      end else if (accept) begin
         page_known <= 1'b1;
         last_page  <= addr[ADDR_W-1:COL_W];
      end else if (idle_next) begin
         page_known <= 1'b0;
      end
   end

   assign near = accept && page_known && (addr[ADDR_W-1:COL_W] == last_page);
endmodule

// File: rtl/dpc_beat_ctl.sv
module dpc_beat_ctl
   import dpc_pkg::*;
#(
   parameter bit NARROW_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  byte_mode,
   input  logic                  active,
   input  logic                  ready,
   input  dpc_be_t               head_be,
   input  dpc_word_t             head_wdata,
   input  dpc_word_t             rdata,
   output logic [DPC_BEAT_W-1:0] beat,
   output logic                  last_beat,
   output dpc_be_t               lane_be,
   output dpc_word_t             lane_wdata,
   output dpc_word_t             rd_word
);
   generate
      if (NARROW_EN) begin : g_narrow
         logic [DPC_BEAT_W-1:0] beat_q;
         dpc_word_t             gather;
         logic                  step;

         assign step = byte_mode && active && ready;

         always_ff @(posedge clk) begin
            if (!rst_n) beat_q <= '0;
            else if (step) beat_q <= beat_q + 1'b1;
         end

         always_ff @(posedge clk) begin
            if (step) gather[8*beat_q +: 8] <= rdata[7:0];
         end

         always_comb begin
            rd_word = rdata;
            if (byte_mode) begin
               rd_word = gather;
               rd_word[DPC_DATA_W-8 +: 8] = rdata[7:0];
            end
         end

         assign beat       = beat_q;
         assign last_beat  = !byte_mode || (beat_q == DPC_BEAT_W'(DPC_LANES - 1));
         assign lane_be    = byte_mode ? dpc_be_t'(head_be[beat_q]) : head_be;
         assign lane_wdata = byte_mode ? dpc_word_t'(head_wdata[8*beat_q +: 8]) : head_wdata;
      end else begin : g_wide
         assign beat       = '0;
         assign last_beat  = 1'b1;
         assign lane_be    = head_be;
         assign lane_wdata = head_wdata;
         assign rd_word    = rdata;
      end
   endgenerate
endmodule

// File: rtl/dram_pipe_ctrl.sv
module dram_pipe_ctrl
   import dpc_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int COL_W     = 11,
   parameter int DEPTH     = 3,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  byte_mode,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DPC_LANES-1:0]  req_be,
   input  logic [DPC_DATA_W-1:0] req_wdata,
   output logic                  rsp_valid,
   output logic                  rsp_write,
   output logic [DPC_DATA_W-1:0] rsp_rdata,
   output logic                  bus_adr_valid,
   output logic [ADDR_W-1:0]     bus_addr,
   output logic                  bus_adr_wr,
   output logic                  bus_near,
   output logic                  dat_active,
   output logic                  dat_wr,
   output logic [DPC_LANES-1:0]  dat_be,
   output logic [DPC_BEAT_W-1:0] dat_beat,
   output logic [DPC_DATA_W-1:0] dat_wdata,
   input  logic [DPC_DATA_W-1:0] dat_rdata,
   input  logic                  dat_ready
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int PW    = ADDR_W + 1 + DPC_LANES + DPC_DATA_W;

   initial begin
      assert (DEPTH >= 1 && DEPTH <= 7) else $error("DEPTH out of range");
      assert (COL_W >= 3 && COL_W < ADDR_W) else $error("COL_W out of range");
   end

   logic [CNT_W-1:0]  occ;
   logic [PW-1:0]     head;
   logic              accept, retire, idle_next, last_beat, narrow;
   logic [ADDR_W-1:0] head_addr;
   logic              head_wr;
   dpc_be_t           head_be;
   dpc_word_t         head_wdata, rd_word;

   assign narrow    = NARROW_EN && byte_mode;
   assign req_ready = narrow ? (occ == '0) : (occ < CNT_W'(DEPTH));
   assign accept    = req_valid && req_ready;
   assign dat_active = (occ != '0);
   assign retire    = dat_active && dat_ready && last_beat;
   assign idle_next = !accept && ((occ == '0) || ((occ == CNT_W'(1)) && retire));

   assign {head_addr, head_wr, head_be, head_wdata} = head;

   dpc_queue #(.DEPTH(DEPTH), .W(PW)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (accept),
      .pop   (retire),
      .din   ({req_addr, req_write, req_be, req_wdata}),
      .dout  (head),
      .count (occ)
   );

   dpc_page_track #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_page (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .idle_next (idle_next),
      .addr      (req_addr),
      .near      (bus_near)
   );

   dpc_beat_ctl #(.NARROW_EN(NARROW_EN)) u_beat (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_mode  (narrow),
      .active     (dat_active),
      .ready      (dat_ready),
      .head_be    (head_be),
      .head_wdata (head_wdata),
      .rdata      (dat_rdata),
      .beat       (dat_beat),
      .last_beat  (last_beat),
      .lane_be    (dat_be),
      .lane_wdata (dat_wdata),
      .rd_word    (rd_word)
   );

   assign bus_adr_valid = accept;
   assign bus_addr      = req_addr;
   assign bus_adr_wr    = req_write;
   assign dat_wr        = head_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_write <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= retire;
         if (retire) begin
            rsp_write <= head_wr;
            rsp_rdata <= head_wr ? '0 : rd_word;
         end
      end
   end
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker
   import dpc_pkg::*;
#(
   parameter int DEPTH = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  byte_mode,
   input logic                  req_ready,
   input logic                  bus_adr_valid,
   input logic                  bus_near,
   input logic                  dat_active,
   input logic                  dat_ready,
   input logic                  dat_wr,
   input logic [DPC_BEAT_W-1:0] dat_beat,
   input logic [DPC_DATA_W-1:0] dat_wdata,
   input logic                  rsp_valid
);
   localparam int CW = $clog2(DEPTH + 1) + 1;

   logic [CW-1:0] seen;
   logic          done_xfer;

   assign done_xfer = dat_active && dat_ready &&
                      (!byte_mode || dat_beat == DPC_BEAT_W'(DPC_LANES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) seen <= '0;
      else seen <= seen + CW'(bus_adr_valid) - CW'(done_xfer);
   end

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      seen <= CW'(DEPTH));
   assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (seen == CW'(DEPTH)) |-> !req_ready);
   assert_resp_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_xfer |=> rsp_valid);
   assert_resp_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !done_xfer |=> !rsp_valid);
   assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_active && !dat_ready && !bus_adr_valid) |=> ($stable(dat_wdata) && $stable(dat_wr)));
   assert_near_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_adr_valid |-> !bus_near);
   assert_idle_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen == '0) |-> !bus_near);
   assert_byte_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_mode && seen != '0) |-> !req_ready);
   assert_wide_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_mode |-> (dat_beat == '0));
endmodule

bind dram_pipe_ctrl dpc_checker #(.DEPTH(DEPTH)) u_dpc_checker (.*);

// File: tb/dram_pipe_ctrl_test.sv
`timescale 1ns/1ps
module dram_pipe_ctrl_test;
   typedef struct {
      logic [31:0] a;
      logic        w;
      logic [7:0]  be;
      logic [63:0] d;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_mode = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [7:0]  req_be = '0;
   logic [63:0] req_wdata = '0;
   logic        req_ready, rsp_valid, rsp_write;
   logic [63:0] rsp_rdata;
   logic        bus_adr_valid, bus_adr_wr, bus_near;
   logic [31:0] bus_addr;
   logic        dat_active, dat_wr;
   logic [7:0]  dat_be;
   logic [2:0]  dat_beat;
   logic [63:0] dat_wdata;
   logic [63:0] dat_rdata = '0;
   logic        dat_ready = 1'b0;

   dram_pipe_ctrl uut (.*);

   always #4 clk = ~clk;

   int    checks = 0, fails = 0;
   int    rdy_mode = 0, tick = 0, bcnt = 0;
   bit    run = 0, ret_prev = 0, pv = 0;
   logic [20:0] lp = '0;
   item_t pend[$], infl[$], resq[$];

   function automatic logic [63:0] mem_word(input logic [31:0] a);
      return {a, a ^ 32'hA5A5_5A5A};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run) begin
         bit    acc, ret;
         int    sz;
         item_t it, h;
         tick++;
         sz = infl.size();
         // R4 R9: completion one cycle after retirement, in order
         chk(rsp_valid == ret_prev, "R4 rsp_valid timing", 64'(rsp_valid), 64'(ret_prev));
         if (ret_prev && resq.size() > 0) begin
            it = resq.pop_front();
            chk(rsp_write == it.w, "R4 rsp_write", 64'(rsp_write), 64'(it.w));
            chk(rsp_rdata == (it.w ? 64'h0 : mem_word(it.a)),
                byte_mode ? "R9 byte assembly" : "R4 read word", rsp_rdata,
                it.w ? 64'h0 : mem_word(it.a));
         end
         // R2 R3 R8: readiness from outstanding count
         if (byte_mode) chk(req_ready == (sz == 0), "R8 single outstanding", 64'(req_ready), 64'(sz == 0));
         else           chk(req_ready == (sz < 3), "R2 R3 ready vs outstanding", 64'(req_ready), 64'(sz < 3));
         // R5 R8: data phase presents the oldest transfer
         chk(dat_active == (sz > 0), "R5 dat_active", 64'(dat_active), 64'(sz > 0));
         if (sz > 0) begin
            h = infl[0];
            chk(dat_wr == h.w, "R5 dat_wr", 64'(dat_wr), 64'(h.w));
            if (byte_mode) begin
               chk(dat_beat == 3'(bcnt), "R8 beat index", 64'(dat_beat), 64'(bcnt));
               chk(dat_be == 8'(h.be[bcnt]), "R8 beat be", 64'(dat_be), 64'(h.be[bcnt]));
               if (h.w) chk(dat_wdata == 64'(h.d[8*bcnt +: 8]), "R8 beat wdata", dat_wdata, 64'(h.d[8*bcnt +: 8]));
            end else begin
               chk(dat_beat == 3'd0, "R8 wide beat zero", 64'(dat_beat), 64'd0);
               chk(dat_be == h.be, "R5 dat_be", 64'(dat_be), 64'(h.be));
               if (h.w) chk(dat_wdata == h.d, "R5 dat_wdata", dat_wdata, h.d);
            end
         end
         // R1 R6 R7: address cycle and same-page flag
         acc = bus_adr_valid;
         if (acc) begin
            if (pend.size() == 0) chk(1'b0, "R1 unexpected address cycle", 64'(bus_addr), 64'd0);
            else begin
               it = pend.pop_front();
               chk(bus_addr == it.a, "R1 bus_addr", 64'(bus_addr), 64'(it.a));
               chk(bus_adr_wr == it.w, "R1 bus_adr_wr", 64'(bus_adr_wr), 64'(it.w));
               chk(bus_near == (pv && it.a[31:11] == lp), "R6 R7 near flag",
                   64'(bus_near), 64'(pv && it.a[31:11] == lp));
               infl.push_back(it);
            end
         end else chk(!bus_near, "R7 near without strobe", 64'(bus_near), 64'd0);
         // memory responder
         case (rdy_mode)
            0: dat_ready = 1'b1;
            1: dat_ready = (tick % 3 == 0);
            default: dat_ready = 1'b0;
         endcase
         dat_rdata = (sz > 0) ? (byte_mode ? 64'(mem_word(infl[0].a) >> (8*bcnt)) & 64'hFF
                                           : mem_word(infl[0].a)) : 64'h0;
         ret = 0;
         if (sz > 0 && dat_ready) begin
            if (!byte_mode || bcnt == 7) begin
               ret = 1;
               bcnt = 0;
               resq.push_back(infl.pop_front());
            end else bcnt++;
         end
         if (acc) begin pv = 1; lp = it.a[31:11]; end
         else if (infl.size() == 0) pv = 0;
         ret_prev = ret;
      end
   end

   // driver: called at posedge+2; leaves at posedge+2 after acceptance
   task automatic send(input bit w, input logic [31:0] a, input logic [7:0] be, input logic [63:0] d);
      item_t it;
      it.a = a; it.w = w; it.be = be; it.d = d;
      pend.push_back(it);
      req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      @(posedge clk); #2;
      req_valid = 1'b0;
   endtask

   task automatic drain();
      do @(posedge clk); while (pend.size() != 0 || infl.size() != 0 || resq.size() != 0);
      repeat (4) @(posedge clk);
      #2;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", fails, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
      chk(!bus_adr_valid && !bus_near, "R10 no address cycle", 64'(bus_adr_valid), 64'd0);
      chk(!dat_active, "R10 data idle", 64'(dat_active), 64'd0);
      chk(!rsp_valid, "R10 no response", 64'(rsp_valid), 64'd0);
      run = 1;
      @(posedge clk); #2;
      // R1 R4 R6: back-to-back, same page then a new page
      send(1, 32'h0000_1000, 8'hFF, 64'h1122_3344_5566_7788);
      send(0, 32'h0000_1008, 8'hFF, 64'h0);
      send(0, 32'h0000_5000, 8'h0F, 64'h0);
      send(1, 32'h0000_5010, 8'hF0, 64'hDEAD_BEEF_0BAD_F00D);
      drain();
      // R7: same page after idle is a miss
      send(0, 32'h0000_5018, 8'hFF, 64'h0);
      drain();
      // R2 R3: fill three deep with the memory stalled
      rdy_mode = 2;
      fork
         begin
            send(0, 32'h0000_9000, 8'hFF, 64'h0);
            send(1, 32'h0000_9008, 8'h3C, 64'hCAFE_0000_1234_5678);
            send(0, 32'h0000_9010, 8'hFF, 64'h0);
            send(0, 32'h0000_9018, 8'hFF, 64'h0);
         end
         begin
            repeat (12) @(negedge clk);
            chk(req_ready == 1'b0, "R2 stall at three outstanding", 64'(req_ready), 64'd0);
            chk(dat_active == 1'b1, "R3 oldest still open", 64'(dat_active), 64'd1);
            rdy_mode = 0;
         end
      join
      drain();
      // R4 R5 R6: slow memory under mixed traffic
      rdy_mode = 1;
      for (int i = 0; i < 8; i++)
         send(i[0], 32'h0000_2000 + 32'(i * 8) + ((i > 4) ? 32'h0001_0000 : 32'h0),
              8'(8'hA5 << i), {32'(i), 32'h5555_0000 + 32'(i)});
      drain();
      rdy_mode = 0;
      // R8 R9: byte-wide boot bus
      byte_mode = 1'b1;
      @(posedge clk); #2;
      send(0, 32'h0000_0100, 8'hFF, 64'h0);
      send(1, 32'h0000_0108, 8'b1010_0110, 64'h0807_0605_0403_0201);
      rdy_mode = 1;
      send(0, 32'h0000_0110, 8'hFF, 64'h0);
      drain();
      rdy_mode = 0;
      byte_mode = 1'b0;
      @(posedge clk); #2;
      send(0, 32'h0000_0118, 8'hFF, 64'h0);
      drain();
      summary();
      $finish;
   end
endmodule